// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM from the host side. A client hands it one command at a time over a valid/ready request port: read, write, erase, erase of the whole array, write of the whole array, and the commands that enable or disable programming. The block turns each request into a serial frame on the clock, select and data-out lines, which it generates itself. On reads it collects the returned word from the data-in line. At the end it reports completion with a single-cycle pulse.

Programming commands need the most care. The select line must be dropped inside a narrow window: after the rising clock edge that carries the last bit, and before any further rising edge. The block drops select together with that last clock fall. It then holds select low for a minimum deselect time and reselects the device. While the device is busy the clock stays idle, and the block watches the returned status level until the device reports ready. A counter limits that wait. If the limit is reached, the command ends with an error.

Top module: `uwire_host`

## Requirements
- R1: The request code selects the frame: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 program-enable, 6 program-disable. Each frame starts with a 1 bit, then a 2-bit opcode (read 10, write 01, erase 11, the other four 00), then the 6-bit address MSB first. For the 00 commands the top two address bits are the sub-code (enable 11, disable 00, erase-all 10, write-all 01) and the rest are zero. Write and write-all then append the 16 data bits MSB first.
- R2: The serial clock is high for exactly DIV system clocks and low for DIV system clocks while a frame is shifted. The data-out line changes only while the serial clock is low. The data-in line is sampled at the moment the serial clock is driven high.
- R3: A read clocks 17 further cycles after the address and skips the leading dummy bit. The 16-bit word on rd_data is valid with a one-cycle rd_valid pulse, which comes together with cmd_done. rd_valid never pulses for a command that is not a read.
- R4: For write, erase, erase-all and write-all, select falls in the same system cycle as the serial clock falls after the final rising edge, so the device starts its programming cycle.
- R5: After a programming frame, select stays low for exactly CSMIN_TICKS·DIV system clocks before it is raised again for status polling.
- R6: While polling, select is high and the serial clock stays low. A data-in level of 1 means ready and 0 means busy. cmd_done is raised only after ready has been seen.
- R7: If ready is not seen within POLL_LIMIT system clocks of polling, select is dropped after exactly POLL_LIMIT clocks high. The command then ends with cmd_err and cmd_done raised together.
- R8: Request code 7 is rejected. cmd_done and cmd_err pulse in the cycle after acceptance, and select is never raised.
- R9: After reset, select and the serial clock are low, req_ready is high and cmd_done is low. req_ready is low while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | Command code (see R1) |
| req_addr | input | 6 | Word address |
| req_data | input | 16 | Data word for write and write-all |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read word |
| rd_data | output | 16 | Word returned by the last read |
| cmd_done | output | 1 | One-cycle pulse at the end of every command |
| cmd_err | output | 1 | With cmd_done: timeout or rejected code |
| ser_clk | output | 1 | Serial clock toward the device |
| chip_sel | output | 1 | Device select, active high |
| ser_out | output | 1 | Serial data toward the device |
| ser_in | input | 1 | Serial data and ready status from the device |

## Verification
The bench runs its own device model. That model accepts a programming frame only if select falls while the serial clock is low and exactly the full bit count has been clocked in. A controller that drops select one edge late or one edge early therefore leaves memory unchanged, and the read-back vectors catch it. The read path is checked on distinct data patterns, so a controller that samples the dummy bit or misses the last data bit returns a word shifted by one position. Directed tests measure the deselect gap, the length of the timeout poll and the absence of clock edges during polling. A stuck-busy device must produce an error rather than a hang, and a rejected code must never raise select.

// File: rtl/uwire_pkg.sv
`timescale 1ns/1ps
package uwire_pkg;

   typedef enum logic [2:0] {
      CMD_READ      = 3'd0,
      CMD_WRITE     = 3'd1,
      CMD_ERASE     = 3'd2,
      CMD_ERASE_ALL = 3'd3,
      CMD_WRITE_ALL = 3'd4,
      CMD_WR_EN     = 3'd5,
      CMD_WR_DIS    = 3'd6
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_DESEL,
      ST_POLL,
      ST_TAIL
   } state_e;

endpackage

// File: rtl/uwire_sk_gen.sv
`timescale 1ns/1ps
module uwire_sk_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("uwire_sk_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CTW = $clog2(DIV);
         logic [CTW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || cnt == CTW'(DIV - 1))
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == CTW'(DIV - 1));

         // R2: half-periods longer than one clock never tick back to back
         assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/uwire_frame.sv
`timescale 1ns/1ps
module uwire_frame
   import uwire_pkg::*;
#(
   parameter  int AW   = 6,
   parameter  int DW   = 16,
   localparam int CMDW = 3 + AW,
   localparam int FW   = CMDW + DW,
   localparam int CW   = $clog2(FW + 2)
) (
   input  logic [2:0]    op,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic [FW-1:0] frame,
   output logic [CW-1:0] nclk,
   output logic          legal,
   output logic          prog,
   output logic          is_rd
);

   logic [1:0]    opb;
   logic [AW-1:0] af;
   logic [DW-1:0] df;

   always_comb begin
      opb   = 2'b00;
      af    = addr;
      df    = '0;
      nclk  = CW'(CMDW);
      legal = 1'b1;
      prog  = 1'b0;
      is_rd = 1'b0;
      case (op)
         CMD_READ: begin
            opb   = 2'b10;
            nclk  = CW'(CMDW + DW + 1);
            is_rd = 1'b1;
         end
         CMD_WRITE: begin
            opb  = 2'b01;
            df   = data;
            nclk = CW'(FW);
            prog = 1'b1;
         end
         CMD_ERASE: begin
            opb  = 2'b11;
            prog = 1'b1;
         end
         CMD_ERASE_ALL: begin
            af            = '0;
            af[AW-1 -: 2] = 2'b10;
            prog          = 1'b1;
         end
         CMD_WRITE_ALL: begin
            af            = '0;
            af[AW-1 -: 2] = 2'b01;
            df            = data;
            nclk          = CW'(FW);
            prog          = 1'b1;
         end
         CMD_WR_EN: begin
            af            = '0;
            af[AW-1 -: 2] = 2'b11;
         end
         CMD_WR_DIS: begin
            af = '0;
         end
         default: legal = 1'b0;
      endcase
      frame = {1'b1, opb, af, df};
   end

endmodule

// File: rtl/uwire_host.sv
`timescale 1ns/1ps
module uwire_host
   import uwire_pkg::*;
#(
   parameter int AW          = 6,
   parameter int DW          = 16,
   parameter int DIV         = 4,
   parameter int CSMIN_TICKS = 2,
   parameter int POLL_LIMIT  = 1000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          cmd_done,
   output logic          cmd_err,
   output logic          ser_clk,
   output logic          chip_sel,
   output logic          ser_out,
   input  logic          ser_in
);

   localparam int CMDW = 3 + AW;
   localparam int FW   = CMDW + DW;
   localparam int CW   = $clog2(FW + 2);
   localparam int DCW  = $clog2(CSMIN_TICKS + 1);
   localparam int TW   = $clog2(POLL_LIMIT + 1);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("uwire_host: AW must be at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("uwire_host: DW must be at least 2");
      end
      if (CSMIN_TICKS < 1) begin : g_bad_cs
         $error("uwire_host: CSMIN_TICKS must be at least 1");
      end
      if (POLL_LIMIT < 2) begin : g_bad_poll
         $error("uwire_host: POLL_LIMIT must be at least 2");
      end
   endgenerate

   state_e         state;
   logic [FW-1:0]  tx;
   logic [DW-1:0]  rx;
   logic [CW-1:0]  idx, nclk_q;
   logic [DCW-1:0] dcnt;
   logic [TW-1:0]  tmo;
   logic           rd_q, prog_q, err_pend;
   logic           cs_q, sk_q, done_q, err_q, rdv_q;
   logic           tick;

   logic [FW-1:0]  f_frame;
   logic [CW-1:0]  f_nclk;
   logic           f_legal, f_prog, f_rd;

   uwire_frame #(.AW(AW), .DW(DW)) frame_i (
      .op    (req_op),
      .addr  (req_addr),
      .data  (req_data),
      .frame (f_frame),
      .nclk  (f_nclk),
      .legal (f_legal),
      .prog  (f_prog),
      .is_rd (f_rd)
   );

   uwire_sk_gen #(.DIV(DIV)) skgen_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state != ST_IDLE),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tx       <= '0;
         rx       <= '0;
         idx      <= '0;
         nclk_q   <= '0;
         dcnt     <= '0;
         tmo      <= '0;
         rd_q     <= 1'b0;
         prog_q   <= 1'b0;
         err_pend <= 1'b0;
         cs_q     <= 1'b0;
         sk_q     <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         rdv_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rdv_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!f_legal) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     tx       <= f_frame;
                     nclk_q   <= f_nclk;
                     rd_q     <= f_rd;
                     prog_q   <= f_prog;
                     idx      <= '0;
                     rx       <= '0;
                     err_pend <= 1'b0;
                     cs_q     <= 1'b1;
                     sk_q     <= 1'b0;
                     state    <= ST_SHIFT;
                  end
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sk_q) begin
                     sk_q <= 1'b1;
                     if (rd_q && idx > CW'(CMDW))
                        rx <= {rx[DW-2:0], ser_in};
                  end else begin
                     sk_q <= 1'b0;
                     if (idx == nclk_q - 1'b1) begin
                        cs_q  <= 1'b0;
                        tx    <= '0;
                        dcnt  <= '0;
                        state <= prog_q ? ST_DESEL : ST_TAIL;
                     end else begin
                        idx <= idx + 1'b1;
                        tx  <= tx << 1;
                     end
                  end
               end
            end
            ST_DESEL: begin
               if (tick) begin
                  if (dcnt == DCW'(CSMIN_TICKS - 1)) begin
                     cs_q  <= 1'b1;
                     tmo   <= '0;
                     state <= ST_POLL;
                  end else begin
                     dcnt <= dcnt + 1'b1;
                  end
               end
            end
            ST_POLL: begin
               tmo <= tmo + 1'b1;
               if (tick && ser_in) begin
                  cs_q  <= 1'b0;
                  dcnt  <= '0;
                  state <= ST_TAIL;
               end else if (tmo == TW'(POLL_LIMIT - 1)) begin
                  cs_q     <= 1'b0;
                  err_pend <= 1'b1;
                  dcnt     <= '0;
                  state    <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  if (dcnt == DCW'(CSMIN_TICKS - 1)) begin
                     done_q   <= 1'b1;
                     err_q    <= err_pend;
                     err_pend <= 1'b0;
                     rdv_q    <= rd_q;
                     state    <= ST_IDLE;
                  end else begin
                     dcnt <= dcnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign ser_clk   = sk_q;
   assign chip_sel  = cs_q;
   assign ser_out   = tx[FW-1];
   assign rd_data   = rx;
   assign rd_valid  = rdv_q;
   assign cmd_done  = done_q;
   assign cmd_err   = err_q;

   // R2: outgoing data holds while the serial clock is high
   assert_di_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_out));

   // R4: the commit drop of select coincides with the clock fall
   assert_commit_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(chip_sel) && state == ST_DESEL) |-> $fell(ser_clk));

   // R6: no serial clock edges while polling status
   assert_poll_sk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POLL) |-> !ser_clk);

   // R3: read data is only flagged at completion
   assert_rdvalid_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> cmd_done);

   // R7: errors are only reported at completion
   assert_err_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> cmd_done);

   // R8: an illegal code finishes at once without selecting the device
   assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 3'd7) |=> (cmd_done && cmd_err && !chip_sel));

   // R9: an idle controller leaves the serial lines quiet
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!chip_sel && !ser_clk));

endmodule

// File: tb/uwire_host_tb_top.sv
`timescale 1ns/1ps
module uwire_host_tb_top;

   localparam int DIV        = 2;
   localparam int CSMIN      = 2;
   localparam int POLL_LIMIT = 3000;
   localparam int BUSY_CLKS  = 400;

   typedef struct packed {
      logic [2:0]  op;
      logic [5:0]  a;
      logic [15:0] d;
      logic [15:0] exp;
      logic        chk;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [0:NV-1] = '{
      '{3'd5, 6'd0,  16'h0000, 16'h0000, 1'b0},
      '{3'd1, 6'd5,  16'h1234, 16'h0000, 1'b0},
      '{3'd0, 6'd5,  16'h0000, 16'h1234, 1'b1},
      '{3'd1, 6'd63, 16'hBEEF, 16'h0000, 1'b0},
      '{3'd0, 6'd63, 16'h0000, 16'hBEEF, 1'b1},
      '{3'd2, 6'd5,  16'h0000, 16'h0000, 1'b0},
      '{3'd0, 6'd5,  16'h0000, 16'hFFFF, 1'b1},
      '{3'd4, 6'd0,  16'hA5A5, 16'h0000, 1'b0},
      '{3'd0, 6'd0,  16'h0000, 16'hA5A5, 1'b1},
      '{3'd0, 6'd40, 16'h0000, 16'hA5A5, 1'b1},
      '{3'd1, 6'd40, 16'h0F0F, 16'h0000, 1'b0},
      '{3'd3, 6'd0,  16'h0000, 16'h0000, 1'b0},
      '{3'd0, 6'd40, 16'h0000, 16'hFFFF, 1'b1},
      '{3'd1, 6'd7,  16'h8001, 16'h0000, 1'b0},
      '{3'd0, 6'd7,  16'h0000, 16'h8001, 1'b1},
      '{3'd6, 6'd0,  16'h0000, 16'h0000, 1'b0},
      '{3'd1, 6'd7,  16'h0000, 16'h0000, 1'b0},
      '{3'd0, 6'd7,  16'h0000, 16'h8001, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_op = 3'd0;
   logic [5:0]  req_addr = 6'd0;
   logic [15:0] req_data = 16'h0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        cmd_done, cmd_err;
   logic        ser_clk, chip_sel, ser_out, ser_in;

   always #4 clk = ~clk;

   uwire_host #(.AW(6), .DW(16), .DIV(DIV), .CSMIN_TICKS(CSMIN), .POLL_LIMIT(POLL_LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd_done(cmd_done), .cmd_err(cmd_err),
      .ser_clk(ser_clk), .chip_sel(chip_sel), .ser_out(ser_out), .ser_in(ser_in)
   );

   // ---------------- device model ----------------
   logic [15:0] mem [0:63];
   logic        wen, rd_mode, do_r, stuck, pcs, psk;
   logic [31:0] sh;
   logic [15:0] osr;
   int          bitcnt, busy, prog_commits, cyc, commit_cyc;

   assign ser_in = rd_mode ? do_r : (chip_sel && bitcnt == 0 && busy == 0 && !stuck);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         for (int k = 0; k < 64; k++) mem[k] <= 16'h0000;
         wen <= 1'b0; rd_mode <= 1'b0; do_r <= 1'b0; pcs <= 1'b0; psk <= 1'b0;
         sh <= '0; osr <= '0; bitcnt <= 0; busy <= 0; prog_commits <= 0; commit_cyc <= 0;
      end else begin
         pcs <= chip_sel;
         psk <= ser_clk;
         if (busy > 0) busy <= busy - 1;
         if (chip_sel && ser_clk && !psk) begin
            sh     <= {sh[30:0], ser_out};
            bitcnt <= bitcnt + 1;
            if (rd_mode) begin
               do_r <= osr[15];
               osr  <= osr << 1;
            end
            if (bitcnt == 8 && sh[7] && sh[6:5] == 2'b10) begin
               rd_mode <= 1'b1;
               do_r    <= 1'b0;
               osr     <= mem[{sh[4:0], ser_out}];
            end
         end
         if (!chip_sel && pcs) begin
            if (!ser_clk && bitcnt == 9 && sh[8]) begin
               if (sh[7:6] == 2'b00 && sh[5:4] == 2'b11) wen <= 1'b1;
               if (sh[7:6] == 2'b00 && sh[5:4] == 2'b00) wen <= 1'b0;
               if (wen && sh[7:6] == 2'b00 && sh[5:4] == 2'b10) begin
                  for (int k = 0; k < 64; k++) mem[k] <= 16'hFFFF;
                  busy <= BUSY_CLKS; prog_commits <= prog_commits + 1; commit_cyc <= cyc;
               end
               if (wen && sh[7:6] == 2'b11) begin
                  mem[sh[5:0]] <= 16'hFFFF;
                  busy <= BUSY_CLKS; prog_commits <= prog_commits + 1; commit_cyc <= cyc;
               end
            end
            if (!ser_clk && bitcnt == 25 && sh[24] && wen) begin
               if (sh[23:22] == 2'b01) begin
                  mem[sh[21:16]] <= sh[15:0];
                  busy <= BUSY_CLKS; prog_commits <= prog_commits + 1; commit_cyc <= cyc;
               end
               if (sh[23:22] == 2'b00 && sh[21:20] == 2'b01) begin
                  for (int k = 0; k < 64; k++) mem[k] <= sh[15:0];
                  busy <= BUSY_CLKS; prog_commits <= prog_commits + 1; commit_cyc <= cyc;
               end
            end
            bitcnt  <= 0;
            rd_mode <= 1'b0;
            do_r    <= 1'b0;
         end
      end
   end

   // ---------------- line monitors ----------------
   logic mcs, msk;
   int   cs_lo, cs_hi, last_lo, last_hi, cs_rises;
   int   sk_lo, sk_hi, last_sklo, last_skhi, poll_sk_rises;

   always @(posedge clk) begin
      if (!rst_n) begin
         mcs <= 1'b0; msk <= 1'b0; cs_lo <= 0; cs_hi <= 0; last_lo <= 0; last_hi <= 0;
         cs_rises <= 0; sk_lo <= 0; sk_hi <= 0; last_sklo <= 0; last_skhi <= 0;
         poll_sk_rises <= 0;
      end else begin
         mcs <= chip_sel;
         msk <= ser_clk;
         if (chip_sel != mcs) begin
            if (chip_sel) begin last_lo <= cs_lo; cs_rises <= cs_rises + 1; end
            else last_hi <= cs_hi;
            cs_lo <= 1; cs_hi <= 1;
         end else begin
            cs_lo <= cs_lo + 1; cs_hi <= cs_hi + 1;
         end
         if (ser_clk != msk) begin
            if (ser_clk) begin
               last_sklo <= sk_lo;
               if (busy > 0) poll_sk_rises <= poll_sk_rises + 1;
            end else last_skhi <= sk_hi;
            sk_lo <= 1; sk_hi <= 1;
         end else begin
            sk_lo <= sk_lo + 1; sk_hi <= sk_hi + 1;
         end
      end
   end

   // ---------------- checking ----------------
   int          nchk = 0, nfail = 0;
   logic        got_rdv, got_err, got_done, ready_busy;
   logic [15:0] got_rdd;
   int          done_cyc;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
      int w;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      ready_busy = req_ready;
      w = 0;
      while (!cmd_done && w < 20000) begin
         @(negedge clk);
         w++;
      end
      got_done = cmd_done;
      got_rdv  = rd_valid;
      got_rdd  = rd_data;
      got_err  = cmd_err;
      done_cyc = cyc;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int pc0, cr0;
      stuck = 1'b0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(chip_sel == 1'b0 && ser_clk == 1'b0, "R9 lines in reset", {chip_sel, ser_clk}, 0);
      check(req_ready == 1'b1 && cmd_done == 1'b0, "R9 ready/done in reset", {req_ready, cmd_done}, 2);
      rst_n = 1'b1;

      // vector table: R1 frame encodings, R3 read path
      for (int i = 0; i < NV; i++) begin
         run_cmd(VECS[i].op, VECS[i].a, VECS[i].d);
         check(got_done == 1'b1 && got_err == 1'b0, $sformatf("R1 vec %0d done/err", i), {got_done, got_err}, 2);
         check(got_rdv == VECS[i].chk, $sformatf("R3 vec %0d rd_valid", i), got_rdv, VECS[i].chk);
         if (VECS[i].chk)
            check(got_rdd == VECS[i].exp, $sformatf("R1/R3 vec %0d rd_data", i), got_rdd, VECS[i].exp);
      end

      // R2 serial clock half-periods
      check(last_skhi == DIV, "R2 clock high length", last_skhi, DIV);
      check(last_sklo == DIV, "R2 clock low length", last_sklo, DIV);

      // R3 rd_valid is a single-cycle pulse
      run_cmd(3'd0, 6'd7, 16'h0);
      @(negedge clk);
      check(rd_valid == 1'b0 && cmd_done == 1'b0, "R3 pulse width", {rd_valid, cmd_done}, 0);

      // R4, R5, R6, R9: programmed write with a busy device
      run_cmd(3'd5, 6'd0, 16'h0);
      pc0 = prog_commits;
      run_cmd(3'd1, 6'd9, 16'h3C5A);
      check(ready_busy == 1'b0, "R9 ready low while busy", ready_busy, 0);
      check(prog_commits == pc0 + 1, "R4 commit accepted", prog_commits, pc0 + 1);
      check(last_lo == CSMIN * DIV, "R5 deselect length", last_lo, CSMIN * DIV);
      check(poll_sk_rises == 0, "R6 clock idle while busy", poll_sk_rises, 0);
      check(done_cyc - commit_cyc >= BUSY_CLKS, "R6 done after ready", done_cyc - commit_cyc, BUSY_CLKS);
      run_cmd(3'd0, 6'd9, 16'h0);
      check(got_rdd == 16'h3C5A, "R4 programmed word", got_rdd, 16'h3C5A);

      // R7 timeout with a device stuck busy
      stuck = 1'b1;
      run_cmd(3'd2, 6'd9, 16'h0);
      check(got_done == 1'b1 && got_err == 1'b1, "R7 timeout error", {got_done, got_err}, 3);
      check(last_hi == POLL_LIMIT, "R7 poll length", last_hi, POLL_LIMIT);
      stuck = 1'b0;

      // R8 illegal code
      cr0 = cs_rises;
      run_cmd(3'd7, 6'd1, 16'h0);
      check(got_done == 1'b1 && got_err == 1'b1, "R8 reject", {got_done, got_err}, 3);
      repeat (4) @(negedge clk);
      check(cs_rises == cr0, "R8 select untouched", cs_rises, cr0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule